// File: doc/BRIEF.md
# Rotating-Priority Interrupt Resolver

This block collects eight asynchronous interrupt request lines, keeps a set of pending requests, a set of levels currently being serviced and a per-level mask, and decides whether the processor may be interrupted. It also decides which level would be granted. The order of the levels is circular and is described by a single "lowest level" pointer. Every other level ranks upward from the level that follows that pointer.

A neighbouring command decoder drives several inputs: mask writes, a special-mask enable, a trigger-mode select, an initialization pulse, an automatic end-of-interrupt pulse, and a command strobe with a 3-bit type and a 3-bit level. An acknowledge strobe commits the current winner. The winner's pending bit is cleared and its in-service bit is set. The pending, in-service and mask vectors are brought out for status reads.

Command type codes on `cmd_type`: 0 = no operation, 1 = non-specific end-of-interrupt, 2 = specific end-of-interrupt, 3 = rotate on non-specific end-of-interrupt, 4 = rotate on specific end-of-interrupt, 5 = set lowest priority, 6 = enable rotation on automatic end-of-interrupt, 7 = disable it. Bit i of every vector port belongs to level i.

Top module: `prio_intr_resolver`

## Requirements
- R1: After reset, and after an `init` pulse, the pending, in-service and mask vectors are zero and `irq` is low. `irq_lvl` reads 7 whenever `irq` is low. Level 0 ranks highest and level 7 lowest.
- R2: When several unmasked requests are pending and nothing is in service, `irq` is high and `irq_lvl` names the highest-ranked one.
- R3: A set mask bit removes its level from resolution, but the level still shows in `pend_vec`. `mask_vec` shows the value written by `mask_we`.
- R4: Outside special mask mode, a level in service blocks every request of equal or lower rank. A strictly higher-ranked unmasked request still raises `irq`.
- R5: An `ack` while `irq` is high clears the pending bit of `irq_lvl` and sets its in-service bit on that clock edge. An `ack` while `irq` is low changes nothing.
- R6: A non-specific end-of-interrupt clears the highest-ranked in-service bit. A specific end-of-interrupt clears the bit given by `cmd_lvl`.
- R7: Rotate on non-specific end-of-interrupt clears the highest-ranked in-service bit and makes that level the lowest, so the next level in circular order ranks highest.
- R8: Set-lowest-priority moves the order without changing any in-service bit. Rotate on specific end-of-interrupt clears `cmd_lvl` and makes it lowest in one step.
- R9: With `spec_mask` high, in-service bits block nothing and a set mask bit blocks only its own level. A non-specific end-of-interrupt then skips in-service bits whose mask bit is set.
- R10: With `level_trig` low, a request is latched on a rising edge and a line held high produces no further request. After `init`, a fresh rising edge is needed. With `level_trig` high, the pending bit follows the line level.
- R11: An `auto_eoi` pulse performs a non-specific clear. When rotation on automatic end-of-interrupt is enabled, the cleared level also becomes lowest.
- R12: A change on a request line reaches `pend_vec` on the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 8 | Asynchronous request lines, bit i is level i |
| level_trig | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| init | input | 1 | Initialization pulse: clears state and re-arms edge detection |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 8 | New mask value, 1 = level masked |
| spec_mask | input | 1 | Special mask mode enable |
| cmd_valid | input | 1 | Command strobe |
| cmd_type | input | 3 | Command type code (see above) |
| cmd_lvl | input | 3 | Level operand of the command |
| auto_eoi | input | 1 | Automatic end-of-interrupt pulse |
| ack | input | 1 | Acknowledge strobe that commits the winner |
| irq | output | 1 | Interrupt request to the processor |
| irq_lvl | output | 3 | Winning level, 7 when `irq` is low |
| pend_vec | output | 8 | Pending request vector |
| isr_vec | output | 8 | In-service vector |
| mask_vec | output | 8 | Mask vector |

## Verification
Resolution is tested with pending patterns that differ in rank: two simultaneous edges, a request above an in-service level and a request below it. Together these separate fixed ordering from nesting. The same requests are then replayed after rotation and after set-lowest commands, so a resolver that ignores the pointer picks a different level. Mask patterns that cover the winner, the in-service level, or both separate normal from special masking. Lines held high across an acknowledge and an init pulse separate edge latching from level following.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int N_LVL = 8;
  localparam int LVL_W = $clog2(N_LVL);

  typedef logic [N_LVL-1:0] lvl_vec_t;
  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_EOI_NS   = 3'd1,
    CMD_EOI_SP   = 3'd2,
    CMD_ROT_NS   = 3'd3,
    CMD_ROT_SP   = 3'd4,
    CMD_SET_LOW  = 3'd5,
    CMD_AROT_ON  = 3'd6,
    CMD_AROT_OFF = 3'd7
  } cmd_e;
endpackage

// File: rtl/prio_req_latch.sv
module prio_req_latch #(
  parameter int N = prio_pkg::N_LVL
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic         level_i,
  input  logic         rearm_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] s1_q, s2_q, prev_q, pend_q;
  logic [N-1:0] prev_d, pend_d, rise;

  always_comb begin
    rise = s2_q & ~prev_q;
    if (level_i) pend_d = s2_q;
    else         pend_d = (pend_q | rise) & s2_q;
    pend_d = pend_d & ~clr_i;
    prev_d = s2_q;
    if (rearm_i) begin
      pend_d = '0;
      prev_d = '1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '1;
      pend_q <= '0;
    end else begin
      s1_q   <= req_i;
      s2_q   <= s1_q;
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R10
  edge_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_i && !rearm_i && (s2_q & prev_q & ~pend_q) != '0)
      |=> ((pend_q & $past(s2_q & prev_q & ~pend_q)) == '0));
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N = prio_pkg::N_LVL,
  parameter int W = prio_pkg::LVL_W
) (
  input  logic [N-1:0] vec_i,
  input  logic [W-1:0] lowest_i,
  output logic         hit_o,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rank_o
);
  always_comb begin
    hit_o  = 1'b0;
    lvl_o  = W'(N - 1);
    rank_o = W'(N - 1);
    for (int k = N - 1; k >= 0; k--) begin
      int idx;
      idx = (int'(lowest_i) + 1 + k) % N;
      if (vec_i[idx]) begin
        hit_o  = 1'b1;
        lvl_o  = W'(idx);
        rank_o = W'(k);
      end
    end
  end
endmodule

// File: rtl/prio_svc.sv
module prio_svc
  import prio_pkg::*;
#(
  parameter int N = N_LVL,
  parameter int W = LVL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rearm_i,
  input  logic         commit_i,
  input  logic [W-1:0] commit_lvl_i,
  input  logic         cmd_valid_i,
  input  logic [2:0]   cmd_type_i,
  input  logic [W-1:0] cmd_lvl_i,
  input  logic         aeoi_i,
  input  logic         ns_hit_i,
  input  logic [W-1:0] ns_lvl_i,
  output logic [N-1:0] isr_o,
  output logic [W-1:0] lowest_o
);
  logic [N-1:0] isr_q, isr_d, clr_vec, set_vec;
  logic [W-1:0] low_q, low_d;
  logic         arot_q, arot_d;
  cmd_e         cmd;

  assign cmd = cmd_e'(cmd_type_i);

  always_comb begin
    clr_vec = '0;
    set_vec = '0;
    low_d   = low_q;
    arot_d  = arot_q;
    if (cmd_valid_i) begin
      case (cmd)
        CMD_EOI_NS:   if (ns_hit_i) clr_vec[ns_lvl_i] = 1'b1;
        CMD_ROT_NS:   if (ns_hit_i) begin
                        clr_vec[ns_lvl_i] = 1'b1;
                        low_d = ns_lvl_i;
                      end
        CMD_EOI_SP:   clr_vec[cmd_lvl_i] = 1'b1;
        CMD_ROT_SP:   begin
                        clr_vec[cmd_lvl_i] = 1'b1;
                        low_d = cmd_lvl_i;
                      end
        CMD_SET_LOW:  low_d = cmd_lvl_i;
        CMD_AROT_ON:  arot_d = 1'b1;
        CMD_AROT_OFF: arot_d = 1'b0;
        default:      ;
      endcase
    end
    if (aeoi_i && ns_hit_i) begin
      clr_vec[ns_lvl_i] = 1'b1;
      if (arot_q) low_d = ns_lvl_i;
    end
    if (commit_i) set_vec[commit_lvl_i] = 1'b1;
    isr_d = (isr_q & ~clr_vec) | set_vec;
    if (rearm_i) begin
      isr_d  = '0;
      low_d  = W'(N - 1);
      arot_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      low_q  <= W'(N - 1);
      arot_q <= 1'b0;
    end else begin
      isr_q  <= isr_d;
      low_q  <= low_d;
      arot_q <= arot_d;
    end
  end

  assign isr_o    = isr_q;
  assign lowest_o = low_q;

  // R5
  commit_sets_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !rearm_i) |=> isr_q[$past(commit_lvl_i)]);

  // R8
  setlow_keeps_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_i && cmd == CMD_SET_LOW && !commit_i && !aeoi_i && !rearm_i)
      |=> $stable(isr_q));

  // R6
  one_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rearm_i |=> $onehot0($past(isr_q) & ~isr_q));
endmodule

// File: rtl/prio_intr_resolver.sv
module prio_intr_resolver
  import prio_pkg::*;
#(
  parameter int N = N_LVL,
  parameter int W = LVL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_in,
  input  logic         level_trig,
  input  logic         init,
  input  logic         mask_we,
  input  logic [N-1:0] mask_wdata,
  input  logic         spec_mask,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_type,
  input  logic [W-1:0] cmd_lvl,
  input  logic         auto_eoi,
  input  logic         ack,
  output logic         irq,
  output logic [W-1:0] irq_lvl,
  output logic [N-1:0] pend_vec,
  output logic [N-1:0] isr_vec,
  output logic [N-1:0] mask_vec
);
  logic [N-1:0] pend, isr, mask_q, mask_d, live, isr_sel, ack_clr;
  logic [W-1:0] lowest, r_lvl, r_rank, s_lvl, s_rank;
  logic         r_hit, s_hit, grant, commit;

  always_comb begin
    mask_d = mask_q;
    if (mask_we) mask_d = mask_wdata;
    if (init)    mask_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign live    = pend & ~mask_q;
  assign isr_sel = spec_mask ? (isr & ~mask_q) : isr;

  prio_pick #(.N(N), .W(W)) u_req_pick (
    .vec_i(live), .lowest_i(lowest),
    .hit_o(r_hit), .lvl_o(r_lvl), .rank_o(r_rank));

  prio_pick #(.N(N), .W(W)) u_isr_pick (
    .vec_i(isr_sel), .lowest_i(lowest),
    .hit_o(s_hit), .lvl_o(s_lvl), .rank_o(s_rank));

  always_comb begin
    grant = r_hit && (spec_mask || !s_hit || (r_rank < s_rank));
    commit = ack && grant;
    ack_clr = '0;
    if (commit) ack_clr[r_lvl] = 1'b1;
  end

  prio_req_latch #(.N(N)) u_req (
    .clk(clk), .rst_n(rst_n), .req_i(req_in), .level_i(level_trig),
    .rearm_i(init), .clr_i(ack_clr), .pend_o(pend));

  prio_svc #(.N(N), .W(W)) u_svc (
    .clk(clk), .rst_n(rst_n), .rearm_i(init),
    .commit_i(commit), .commit_lvl_i(r_lvl),
    .cmd_valid_i(cmd_valid), .cmd_type_i(cmd_type), .cmd_lvl_i(cmd_lvl),
    .aeoi_i(auto_eoi), .ns_hit_i(s_hit), .ns_lvl_i(s_lvl),
    .isr_o(isr), .lowest_o(lowest));

  assign irq      = grant;
  assign irq_lvl  = grant ? r_lvl : W'(N - 1);
  assign pend_vec = pend;
  assign isr_vec  = isr;
  assign mask_vec = mask_q;

  // R3
  irq_needs_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((pend_vec & ~mask_vec) != '0));

  // R5
  commit_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !level_trig && !init) |=> !pend_vec[$past(r_lvl)]);

  // R4
  nest_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!spec_mask && (isr_vec & ~mask_vec & pend_vec) != '0 && $onehot0(pend_vec & ~mask_vec) && (isr_vec & pend_vec & ~mask_vec) == (pend_vec & ~mask_vec)) |-> !irq);
endmodule

// File: tb/test_prio_intr_resolver.sv
module test_prio_intr_resolver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_in = '0;
  logic       level_trig = 1'b0;
  logic       init = 1'b0;
  logic       mask_we = 1'b0;
  logic [7:0] mask_wdata = '0;
  logic       spec_mask = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_type = '0;
  logic [2:0] cmd_lvl = '0;
  logic       auto_eoi = 1'b0;
  logic       ack = 1'b0;
  logic       irq;
  logic [2:0] irq_lvl;
  logic [7:0] pend_vec, isr_vec, mask_vec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prio_intr_resolver i_prio_intr_resolver (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .level_trig(level_trig),
    .init(init), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .spec_mask(spec_mask), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_lvl(cmd_lvl), .auto_eoi(auto_eoi), .ack(ack), .irq(irq),
    .irq_lvl(irq_lvl), .pend_vec(pend_vec), .isr_vec(isr_vec),
    .mask_vec(mask_vec));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(1); ack = 1'b0;
  endtask

  task automatic do_cmd(input logic [2:0] t, input logic [2:0] l);
    cmd_valid = 1'b1; cmd_type = t; cmd_lvl = l; tick(1);
    cmd_valid = 1'b0; cmd_type = '0; cmd_lvl = '0;
  endtask

  task automatic do_mask(input logic [7:0] m);
    mask_we = 1'b1; mask_wdata = m; tick(1); mask_we = 1'b0;
  endtask

  task automatic do_init();
    init = 1'b1; tick(1); init = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pend", pend_vec, 8'h00);
    chk("R1 isr", isr_vec, 8'h00);
    chk("R1 mask", mask_vec, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 lvl", {5'd0, irq_lvl}, 8'h07);
  endtask

  task automatic t_order();
    req_in = 8'h28;
    tick(2);
    chk("R12 not yet", pend_vec, 8'h00);
    tick(1);
    chk("R12 pend", pend_vec, 8'h28);
    chk("R2 irq", {7'd0, irq}, 8'h01);
    chk("R2 lvl", {5'd0, irq_lvl}, 8'h03);
  endtask

  task automatic t_mask();
    do_mask(8'h08);
    chk("R3 mask readback", mask_vec, 8'h08);
    chk("R3 lvl past mask", {5'd0, irq_lvl}, 8'h05);
    chk("R3 pend unaffected", pend_vec, 8'h28);
    do_mask(8'h28);
    chk("R3 all masked irq", {7'd0, irq}, 8'h00);
    do_mask(8'h00);
  endtask

  task automatic t_nest();
    do_ack();
    chk("R5 isr set", isr_vec, 8'h08);
    chk("R5 pend cleared", pend_vec, 8'h20);
    chk("R4 lower blocked", {7'd0, irq}, 8'h00);
    req_in = 8'h2A;
    tick(3);
    chk("R4 higher irq", {7'd0, irq}, 8'h01);
    chk("R4 higher lvl", {5'd0, irq_lvl}, 8'h01);
    do_ack();
    chk("R5 nested isr", isr_vec, 8'h0A);
    do_cmd(3'd1, 3'd0);
    chk("R6 nonspecific", isr_vec, 8'h08);
    chk("R4 still blocked", {7'd0, irq}, 8'h00);
    do_cmd(3'd2, 3'd3);
    chk("R6 specific", isr_vec, 8'h00);
    chk("R6 lvl after clear", {5'd0, irq_lvl}, 8'h05);
    do_ack();
    chk("R5 isr5", isr_vec, 8'h20);
    tick(3);
    chk("R10 held high no repeat", pend_vec, 8'h00);
    do_ack();
    chk("R5 empty ack isr", isr_vec, 8'h20);
    chk("R5 empty ack lvl", {5'd0, irq_lvl}, 8'h07);
  endtask

  task automatic t_rotate();
    do_cmd(3'd3, 3'd0);
    chk("R7 rot clear", isr_vec, 8'h00);
    req_in = 8'h00; tick(3);
    req_in = 8'h41; tick(3);
    chk("R7 rotated winner", {5'd0, irq_lvl}, 8'h06);
    do_cmd(3'd5, 3'd6);
    chk("R8 set low winner", {5'd0, irq_lvl}, 8'h00);
    do_ack();
    chk("R8 isr0", isr_vec, 8'h01);
    do_cmd(3'd5, 3'd0);
    chk("R8 isr untouched", isr_vec, 8'h01);
    chk("R8 reorder irq", {7'd0, irq}, 8'h01);
    chk("R8 reorder lvl", {5'd0, irq_lvl}, 8'h06);
    do_ack();
    chk("R8 isr both", isr_vec, 8'h41);
    do_cmd(3'd4, 3'd6);
    chk("R8 rot specific", isr_vec, 8'h01);
  endtask

  task automatic t_init();
    do_init();
    chk("R1 init isr", isr_vec, 8'h00);
    tick(3);
    chk("R10 init needs edge", pend_vec, 8'h00);
    chk("R1 init irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_special();
    req_in = 8'h00; tick(3);
    req_in = 8'h04; tick(3);
    do_ack();
    chk("R5 isr2", isr_vec, 8'h04);
    req_in = 8'h14; tick(3);
    chk("R4 lower than isr", {7'd0, irq}, 8'h00);
    spec_mask = 1'b1; tick(1);
    chk("R9 isr ignored", {5'd0, irq_lvl}, 8'h04);
    do_mask(8'h10);
    chk("R9 own mask", {7'd0, irq}, 8'h00);
    do_mask(8'h04);
    chk("R9 other masked", {7'd0, irq}, 8'h01);
    do_ack();
    chk("R9 isr", isr_vec, 8'h14);
    do_cmd(3'd1, 3'd0);
    chk("R9 eoi skips masked", isr_vec, 8'h04);
    spec_mask = 1'b0;
    do_mask(8'h00);
  endtask

  task automatic t_level();
    do_init();
    level_trig = 1'b1;
    req_in = 8'h80; tick(3);
    chk("R10 level pend", pend_vec, 8'h80);
    chk("R10 level lvl", {5'd0, irq_lvl}, 8'h07);
    req_in = 8'h00; tick(3);
    chk("R10 level follows", pend_vec, 8'h00);
  endtask

  task automatic t_auto();
    req_in = 8'h84; tick(3);
    chk("R11 pre lvl", {5'd0, irq_lvl}, 8'h02);
    do_ack();
    auto_eoi = 1'b1; tick(1); auto_eoi = 1'b0;
    chk("R11 auto clear", isr_vec, 8'h00);
    chk("R11 no rotate lvl", {5'd0, irq_lvl}, 8'h02);
    do_cmd(3'd6, 3'd0);
    do_ack();
    chk("R11 isr2", isr_vec, 8'h04);
    auto_eoi = 1'b1; tick(1); auto_eoi = 1'b0;
    chk("R11 rotate clear", isr_vec, 8'h00);
    chk("R11 rotated lvl", {5'd0, irq_lvl}, 8'h07);
  endtask

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_order();
    t_mask();
    t_nest();
    t_rotate();
    t_init();
    t_special();
    t_level();
    t_auto();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule